// File: doc/BRIEF.md
# ATAPI Packet Transfer Sequencer

This block is the device-side phase controller for a PACKET command on an ATA interface. When the host writes the PACKET opcode, the block latches the host's byte-count limit and raises DRQ so the host can send a 12-byte command packet as six 16-bit words. Once all six words are in, the packet goes to an external command engine over a valid/ready handshake. The engine then returns a response: a data length, a direction, and an error flag with a sense key.

The block then moves the data in chunks. Each chunk size is published in the byte-count registers, and each chunk opens with an interrupt and DRQ. Host data words go to or come from an external buffer. The buffer address is the chunk base plus the offset inside the chunk. When the data is exhausted, or the command failed or returned nothing, the block enters the status phase and raises a completion interrupt. Command execution, buffer storage and host register decoding are outside this block.

Top module: `atapi_packet_seq`

## Requirements
- R1: Only opcode 0xA0 written while the sequencer is idle or finished starts a command; any other opcode leaves every output unchanged. After reset the status is 0x40 (DRDY, bit 6), the interrupt reason is 0 and irq is low.
- R2: In the packet phase the status is 0x08 (DRQ, bit 3), the interrupt reason is 0x01 and irq stays low. The six written words appear on pkt_data, with word i at bits 16i+15..16i. pkt_valid then holds with stable data until pkt_ready.
- R3: The interrupt reason uses bit 0 for command/data and bit 1 for direction. The values are: packet 0x01, data toward host 0x02, data from host 0x00, completion 0x03.
- R4: Each chunk is the smallest of the remaining length, the host limit (65535 read as 65534) and 32768, with bit 0 cleared. A result of 0 is raised to 2. The chunk size is shown on bcnt_hi:bcnt_lo.
- R5: Each chunk starts with irq high and status 0x08. In the cycle after the last word of a chunk, the status is 0x80 (BSY, bit 7).
- R6: The buffer byte address equals the chunk base plus the offset in the chunk, and advances by 2 per word. For data toward the host, host_rdata equals buf_rdata; for data from the host, buf_wdata equals host_wdata.
- R7: At completion the status is 0x40, the interrupt reason is 0x03 and irq rises.
- R8: On an error response the error output becomes {sense, 4'b0100}, the status becomes 0x41 (CHK, bit 0), and no data phase takes place.
- R9: A response length of 0 goes directly to completion after the packet phase.
- R10: Host data reads or writes while DRQ is low cause no buffer access, and a read returns 0.
- R11: A status read (stat_rd) clears irq.
- R12: When fewer than 2 bytes remain after a chunk, the transfer completes, so an odd final byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Opcode written |
| bcnt_lo_in | input | 8 | Host byte-count limit, low byte |
| bcnt_hi_in | input | 8 | Host byte-count limit, high byte |
| stat_rd | input | 1 | Status register read strobe |
| host_rd | input | 1 | Host data word read strobe |
| host_wr | input | 1 | Host data word write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| status | output | 8 | Status register |
| error | output | 8 | Error register |
| ireason | output | 8 | Interrupt reason (sector count) |
| bcnt_lo | output | 8 | Chunk byte count, low byte |
| bcnt_hi | output | 8 | Chunk byte count, high byte |
| irq | output | 1 | Interrupt request |
| pkt_valid | output | 1 | Command packet valid |
| pkt_ready | input | 1 | Engine accepts packet |
| pkt_data | output | 96 | Command packet, six words |
| rsp_valid | input | 1 | Engine response valid |
| rsp_ready | output | 1 | Sequencer accepts response |
| rsp_len | input | 20 | Response data length in bytes |
| rsp_to_dev | input | 1 | 1: data flows from host to device |
| rsp_err | input | 1 | Command failed |
| rsp_sense | input | 4 | Sense key on failure |
| buf_addr | output | 20 | Buffer byte address |
| buf_rd | output | 1 | Buffer read strobe |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 16 | Buffer write data |
| buf_rdata | input | 16 | Buffer read data |

## Verification
A wrong chunk size, base or offset is visible on the first word of the affected chunk. It shows up as a wrong buf_addr or returned word, or as a wrong bcnt value when the chunk interrupt is raised. A stuck or skipped phase shows up within one cycle as a wrong status or interrupt reason. It can also show up as a missing interrupt, which the bench catches through bounded polling. Lost words in the packet collector show up when pkt_data is compared as soon as pkt_valid rises.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PKT, S_HAND, S_EXEC, S_LOAD, S_XFER, S_FIN, S_DONE
  } seq_state_e;

  localparam logic [7:0] OP_PACKET = 8'hA0;
  localparam int ST_CHK  = 0;
  localparam int ST_DRQ  = 3;
  localparam int ST_DRDY = 6;
  localparam int ST_BSY  = 7;
  localparam logic [3:0] ERR_ABORT = 4'h4;
  localparam logic [7:0] IR_PACKET = 8'h01;
  localparam logic [7:0] IR_TO_HOST = 8'h02;
  localparam logic [7:0] IR_FROM_HOST = 8'h00;
  localparam logic [7:0] IR_COMPLETE = 8'h03;
endpackage

// File: rtl/atapi_pkt_collect.sv
module atapi_pkt_collect #(
  parameter int WORDS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [15:0]          wdata,
  output logic                 last,
  output logic [16*WORDS-1:0]  pkt
);
  localparam int CNTW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign last   = (cnt_q == CNTW'(WORDS - 1));
  assign cnt_en = clr | wr_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (wr_en) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [15:0] word_q;
    logic        word_en;
    assign word_en = wr_en && (cnt_q == CNTW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= wdata;
    end
    assign pkt[16*i +: 16] = word_q;
  end
endmodule

// File: rtl/atapi_chunk_calc.sv
module atapi_chunk_calc #(
  parameter int LEN_W     = 20,
  parameter int CHUNK_MAX = 32768,
  parameter int CNT_W     = 16
) (
  input  logic [LEN_W-1:0] remaining,
  input  logic [15:0]      limit,
  output logic [CNT_W-1:0] chunk
);
  localparam int CW = (LEN_W > 17) ? LEN_W : 17;

  logic [CW-1:0] r, l, cap, m1, m2;

  always_comb begin
    r   = CW'(remaining);
    l   = (limit == 16'hFFFF) ? CW'(16'hFFFE) : CW'(limit);
    cap = CW'(CHUNK_MAX);
    m1  = (r < l) ? r : l;
    m2  = (m1 < cap) ? m1 : cap;
    m2[0] = 1'b0;
    if (m2 == '0) m2 = CW'(2);
    chunk = CNT_W'(m2);
  end
endmodule

// File: rtl/atapi_xfer_ctr.sv
module atapi_xfer_ctr #(
  parameter int LEN_W = 20,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             step,
  input  logic [CNT_W-1:0] chunk,
  output logic             chunk_last,
  output logic [LEN_W-1:0] rem_after,
  output logic [LEN_W-1:0] addr
);
  logic [LEN_W-1:0] rem_q, rem_d, base_q, base_d;
  logic [CNT_W-1:0] off_q, off_d;
  logic             en;

  assign chunk_last = ({1'b0, off_q} + (CNT_W+1)'(2)) == {1'b0, chunk};
  assign rem_after  = rem_q - LEN_W'(chunk);
  assign addr       = base_q + LEN_W'(off_q);
  assign en         = load | step;

  always_comb begin
    rem_d  = rem_q;
    base_d = base_q;
    off_d  = off_q;
    if (load) begin
      rem_d  = load_len;
      base_d = '0;
      off_d  = '0;
    end else if (step) begin
      if (chunk_last) begin
        rem_d  = rem_after;
        base_d = base_q + LEN_W'(chunk);
        off_d  = '0;
      end else begin
        off_d  = off_q + CNT_W'(2);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      base_q <= '0;
      off_q  <= '0;
    end else if (en) begin
      rem_q  <= rem_d;
      base_q <= base_d;
      off_q  <= off_d;
    end
  end
endmodule

// File: rtl/atapi_packet_seq.sv
module atapi_packet_seq
  import atapi_seq_pkg::*;
#(
  parameter int LEN_W     = 20,
  parameter int CHUNK_MAX = 32768,
  parameter int PKT_WORDS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_we,
  input  logic [7:0]             cmd_code,
  input  logic [7:0]             bcnt_lo_in,
  input  logic [7:0]             bcnt_hi_in,
  input  logic                   stat_rd,
  input  logic                   host_rd,
  input  logic                   host_wr,
  input  logic [15:0]            host_wdata,
  output logic [15:0]            host_rdata,
  output logic [7:0]             status,
  output logic [7:0]             error,
  output logic [7:0]             ireason,
  output logic [7:0]             bcnt_lo,
  output logic [7:0]             bcnt_hi,
  output logic                   irq,
  output logic                   pkt_valid,
  input  logic                   pkt_ready,
  output logic [16*PKT_WORDS-1:0] pkt_data,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic [LEN_W-1:0]       rsp_len,
  input  logic                   rsp_to_dev,
  input  logic                   rsp_err,
  input  logic [3:0]             rsp_sense,
  output logic [LEN_W-1:0]       buf_addr,
  output logic                   buf_rd,
  output logic                   buf_wr,
  output logic [15:0]            buf_wdata,
  input  logic [15:0]            buf_rdata
);
  localparam int CNT_W = $clog2(CHUNK_MAX + 1);

  seq_state_e st_q, st_d;
  logic       to_dev_q, to_dev_d;
  logic       chk_q, chk_d;
  logic       irq_q, irq_d;
  logic [7:0] err_q, err_d;
  logic [7:0] ir_q, ir_d;
  logic [15:0] limit_q, limit_d;
  logic [15:0] bcnt_q, bcnt_d;
  logic [CNT_W-1:0] chunk_q, chunk_d, chunk_calc;
  logic       reg_en;

  logic cmd_go, pkt_wr, pkt_last, rsp_take, data_acc, chunk_last;
  logic [LEN_W-1:0] rem_after, xfer_addr, cur_rem;

  assign cmd_go   = cmd_we && (cmd_code == OP_PACKET) &&
                    ((st_q == S_IDLE) || (st_q == S_DONE));
  assign pkt_wr   = (st_q == S_PKT) && host_wr;
  assign rsp_take = (st_q == S_EXEC) && rsp_valid;
  assign data_acc = (st_q == S_XFER) && (to_dev_q ? host_wr : host_rd);

  atapi_pkt_collect #(.WORDS(PKT_WORDS)) u_collect (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd_go),
    .wr_en (pkt_wr),
    .wdata (host_wdata),
    .last  (pkt_last),
    .pkt   (pkt_data)
  );

  atapi_xfer_ctr #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (rsp_take),
    .load_len   (rsp_len),
    .step       (data_acc),
    .chunk      (chunk_q),
    .chunk_last (chunk_last),
    .rem_after  (rem_after),
    .addr       (xfer_addr)
  );

  // remaining length seen by the chunk calculator is the counter state;
  // rem_after with a zero chunk reproduces it.
  assign cur_rem = rem_after + LEN_W'(chunk_q);

  atapi_chunk_calc #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX), .CNT_W(CNT_W)) u_calc (
    .remaining (cur_rem),
    .limit     (limit_q),
    .chunk     (chunk_calc)
  );

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE, S_DONE: if (cmd_go) st_d = S_PKT;
      S_PKT:  if (pkt_wr && pkt_last) st_d = S_HAND;
      S_HAND: if (pkt_ready) st_d = S_EXEC;
      S_EXEC: if (rsp_valid) st_d = (rsp_err || (rsp_len < LEN_W'(2))) ? S_FIN : S_LOAD;
      S_LOAD: st_d = S_XFER;
      S_XFER: if (data_acc && chunk_last) st_d = (rem_after < LEN_W'(2)) ? S_FIN : S_LOAD;
      S_FIN:  st_d = S_DONE;
      default: st_d = S_IDLE;
    endcase
  end

  // register next values
  always_comb begin
    to_dev_d = to_dev_q;
    chk_d    = chk_q;
    err_d    = err_q;
    ir_d     = ir_q;
    limit_d  = limit_q;
    bcnt_d   = bcnt_q;
    chunk_d  = chunk_q;
    irq_d    = irq_q;
    if (stat_rd) irq_d = 1'b0;
    if (cmd_go) begin
      ir_d    = IR_PACKET;
      err_d   = '0;
      chk_d   = 1'b0;
      irq_d   = 1'b0;
      limit_d = {bcnt_hi_in, bcnt_lo_in};
      bcnt_d  = {bcnt_hi_in, bcnt_lo_in};
      chunk_d = '0;
    end
    if (rsp_take) begin
      to_dev_d = rsp_to_dev;
      chunk_d  = '0;
      if (rsp_err) begin
        err_d = {rsp_sense, ERR_ABORT};
        chk_d = 1'b1;
      end
    end
    if (st_q == S_LOAD) begin
      chunk_d = chunk_calc;
      bcnt_d  = 16'(chunk_calc);
      ir_d    = to_dev_q ? IR_FROM_HOST : IR_TO_HOST;
      irq_d   = 1'b1;
    end
    if (st_q == S_FIN) begin
      ir_d  = IR_COMPLETE;
      irq_d = 1'b1;
    end
    if ((st_q == S_XFER) && data_acc && chunk_last) chunk_d = '0;
  end

  assign reg_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      to_dev_q <= 1'b0;
      chk_q    <= 1'b0;
      err_q    <= '0;
      ir_q     <= '0;
      limit_q  <= '0;
      bcnt_q   <= '0;
      chunk_q  <= '0;
      irq_q    <= 1'b0;
    end else if (reg_en) begin
      st_q     <= st_d;
      to_dev_q <= to_dev_d;
      chk_q    <= chk_d;
      err_q    <= err_d;
      ir_q     <= ir_d;
      limit_q  <= limit_d;
      bcnt_q   <= bcnt_d;
      chunk_q  <= chunk_d;
      irq_q    <= irq_d;
    end
  end

  // outputs
  always_comb begin
    status = '0;
    status[ST_BSY]  = (st_q == S_HAND) || (st_q == S_EXEC) ||
                      (st_q == S_LOAD) || (st_q == S_FIN);
    status[ST_DRQ]  = (st_q == S_PKT) || (st_q == S_XFER);
    status[ST_DRDY] = (st_q == S_IDLE) || (st_q == S_DONE);
    status[ST_CHK]  = (st_q == S_DONE) && chk_q;
  end

  assign error      = err_q;
  assign ireason    = ir_q;
  assign bcnt_lo    = bcnt_q[7:0];
  assign bcnt_hi    = bcnt_q[15:8];
  assign irq        = irq_q;
  assign pkt_valid  = (st_q == S_HAND);
  assign rsp_ready  = (st_q == S_EXEC);
  assign buf_addr   = xfer_addr;
  assign buf_rd     = (st_q == S_XFER) && !to_dev_q && host_rd;
  assign buf_wr     = (st_q == S_XFER) && to_dev_q && host_wr;
  assign buf_wdata  = host_wdata;
  assign host_rdata = buf_rd ? buf_rdata : 16'h0000;
endmodule

// File: rtl/atapi_packet_seq_chk.sv
module atapi_packet_seq_chk #(
  parameter int CHUNK_MAX = 32768,
  parameter int PKT_WORDS = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [7:0]              status,
  input logic [7:0]              error,
  input logic [7:0]              ireason,
  input logic [7:0]              bcnt_lo,
  input logic [7:0]              bcnt_hi,
  input logic                    irq,
  input logic                    pkt_valid,
  input logic                    pkt_ready,
  input logic [16*PKT_WORDS-1:0] pkt_data,
  input logic                    buf_rd,
  input logic                    buf_wr
);
  p_drq_bsy_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3]));

  p_buf_needs_drq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd || buf_wr) |-> status[3]);

  p_even_chunk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && ireason[1:0] != 2'b01) |->
      (bcnt_lo[0] == 1'b0 && {bcnt_hi, bcnt_lo} != 16'd0 &&
       {bcnt_hi, bcnt_lo} <= 16'(CHUNK_MAX)));

  p_pkt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

  p_pkt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && ireason[1:0] == 2'b01) |-> !irq);

  p_chk_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (error[3:0] == 4'h4));

  p_done_reason_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && irq) |-> (ireason[1:0] == 2'b11));
endmodule

bind atapi_packet_seq atapi_packet_seq_chk #(
  .CHUNK_MAX (CHUNK_MAX),
  .PKT_WORDS (PKT_WORDS)
) u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .status    (status),
  .error     (error),
  .ireason   (ireason),
  .bcnt_lo   (bcnt_lo),
  .bcnt_hi   (bcnt_hi),
  .irq       (irq),
  .pkt_valid (pkt_valid),
  .pkt_ready (pkt_ready),
  .pkt_data  (pkt_data),
  .buf_rd    (buf_rd),
  .buf_wr    (buf_wr)
);

// File: tb/test_atapi_packet_seq.sv
`timescale 1ns/1ps
module test_atapi_packet_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we, stat_rd, host_rd, host_wr;
  logic [7:0]  cmd_code, bcnt_lo_in, bcnt_hi_in;
  logic [15:0] host_wdata, host_rdata;
  logic [7:0]  status, error, ireason, bcnt_lo, bcnt_hi;
  logic        irq, pkt_valid, pkt_ready, rsp_valid, rsp_ready;
  logic [95:0] pkt_data;
  logic [19:0] rsp_len, buf_addr;
  logic        rsp_to_dev, rsp_err, buf_rd, buf_wr;
  logic [3:0]  rsp_sense;
  logic [15:0] buf_wdata, buf_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [35:0] exp_q[$];
  logic [35:0] got_q[$];

  always #2.5 clk = ~clk;

  function automatic logic [15:0] word_at(input logic [19:0] a);
    return {a[7:0], a[15:8] ^ 8'hC3};
  endfunction

  assign buf_rdata = word_at(buf_addr);
  assign pkt_ready = 1'b1;

  atapi_packet_seq i_atapi_packet_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .bcnt_lo_in(bcnt_lo_in), .bcnt_hi_in(bcnt_hi_in), .stat_rd(stat_rd),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .status(status), .error(error), .ireason(ireason),
    .bcnt_lo(bcnt_lo), .bcnt_hi(bcnt_hi), .irq(irq), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_data(pkt_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_len(rsp_len), .rsp_to_dev(rsp_to_dev),
    .rsp_err(rsp_err), .rsp_sense(rsp_sense), .buf_addr(buf_addr),
    .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata)
  );

  // monitor: every buffer write the design produces
  always @(posedge clk) if (rst_n && buf_wr) got_q.push_back({buf_addr[19:0], buf_wdata});

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wait_irq(input string req);
    int k = 0;
    while (!irq && k < 40) begin @(negedge clk); k++; end
    check(req, {31'd0, irq}, 32'd1);
  endtask

  task automatic drain_writes(input string req);
    while (exp_q.size() > 0) begin
      logic [35:0] e = exp_q.pop_front();
      logic [35:0] g = (got_q.size() > 0) ? got_q.pop_front() : 36'hFFFFFFFFF;
      check(req, g[31:0], e[31:0]);
      check(req, {28'd0, g[35:32]}, {28'd0, e[35:32]});
    end
    check(req, got_q.size(), 0);
  endtask

  task automatic run_cmd(input logic [15:0] limit, input int len, input bit to_dev,
                         input bit err, input logic [3:0] sense);
    int rem = len;
    int base = 0;
    logic [95:0] exp_pkt;
    rsp_len = 20'(len); rsp_to_dev = to_dev; rsp_err = err; rsp_sense = sense;
    rsp_valid = 1'b1;
    @(negedge clk);
    cmd_we = 1'b1; cmd_code = 8'hA0; bcnt_lo_in = limit[7:0]; bcnt_hi_in = limit[15:8];
    @(negedge clk);
    cmd_we = 1'b0;
    check("R2 packet status", {24'd0, status}, 32'h08);
    check("R3 packet reason", {24'd0, ireason}, 32'h01);
    check("R2 no irq in packet phase", {31'd0, irq}, 32'd0);
    for (int k = 0; k < 6; k++) begin
      host_wr = 1'b1; host_wdata = 16'(len + 16'h1111 * k);
      exp_pkt[16*k +: 16] = host_wdata;
      @(negedge clk);
    end
    host_wr = 1'b0;
    check("R2 pkt_valid", {31'd0, pkt_valid}, 32'd1);
    check("R2 pkt_data lo", pkt_data[31:0], exp_pkt[31:0]);
    check("R2 pkt_data hi", pkt_data[95:64], exp_pkt[95:64]);
    begin
      int k = 0;
      while (!rsp_ready && k < 10) begin @(negedge clk); k++; end
    end
    @(negedge clk);
    rsp_valid = 1'b0;
    if (!err) begin
      while (rem >= 2) begin
        int lim = (limit == 16'hFFFF) ? 65534 : int'(limit);
        int c = rem;
        if (lim < c) c = lim;
        if (32768 < c) c = 32768;
        c = c & ~1;
        if (c == 0) c = 2;
        wait_irq("R5 chunk irq");
        check("R5 chunk drq", {24'd0, status}, 32'h08);
        check("R4 chunk size", {16'd0, bcnt_hi, bcnt_lo}, 32'(c));
        check("R3 data reason", {24'd0, ireason}, to_dev ? 32'h00 : 32'h02);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        check("R11 irq cleared", {31'd0, irq}, 32'd0);
        for (int w = 0; w < c / 2; w++) begin
          if (to_dev) begin
            host_wr = 1'b1; host_wdata = 16'(w * 7 + base);
            exp_q.push_back({20'(base + 2 * w), host_wdata});
          end else begin
            host_rd = 1'b1;
            #1;
            check("R6 read data", {16'd0, host_rdata}, {16'd0, word_at(20'(base + 2 * w))});
          end
          @(negedge clk);
        end
        host_rd = 1'b0; host_wr = 1'b0;
        check("R5 busy after chunk", {24'd0, status}, 32'h80);
        rem -= c; base += c;
      end
      drain_writes("R6 write stream");
    end
    wait_irq("R7 completion irq");
    check("R7 completion status", {24'd0, status}, err ? 32'h41 : 32'h40);
    check("R7 completion reason", {24'd0, ireason}, 32'h03);
    check("R8 error register", {24'd0, error}, err ? {24'd0, sense, 4'h4} : 32'h0);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    check("R11 irq cleared at end", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_we = 0; stat_rd = 0; host_rd = 0; host_wr = 0;
    cmd_code = 0; bcnt_lo_in = 0; bcnt_hi_in = 0; host_wdata = 0;
    rsp_valid = 0; rsp_len = 0; rsp_to_dev = 0; rsp_err = 0; rsp_sense = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", {24'd0, status}, 32'h40);
    check("R1 reset reason", {24'd0, ireason}, 32'h00);
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    // R1: other opcode ignored
    cmd_we = 1'b1; cmd_code = 8'hEC; @(negedge clk); cmd_we = 1'b0;
    check("R1 other opcode status", {24'd0, status}, 32'h40);
    check("R1 other opcode reason", {24'd0, ireason}, 32'h00);

    // R10: data accesses without DRQ
    host_rd = 1'b1; #1;
    check("R10 idle read returns 0", {16'd0, host_rdata}, 32'h0);
    check("R10 idle read no buffer access", {31'd0, buf_rd}, 32'd0);
    @(negedge clk); host_rd = 1'b0;
    host_wr = 1'b1; host_wdata = 16'hBEEF; @(negedge clk); host_wr = 1'b0;
    check("R10 idle write ignored", got_q.size(), 0);
    check("R10 idle write status", {24'd0, status}, 32'h40);

    run_cmd(16'd4, 10, 1'b0, 1'b0, 4'h0);       // R4 limit-bound chunks
    run_cmd(16'hFFFF, 40000, 1'b0, 1'b0, 4'h0); // R4 65535 and 32 KB ceiling
    run_cmd(16'd7, 8, 1'b0, 1'b0, 4'h0);        // R4 odd limit
    run_cmd(16'd1, 4, 1'b0, 1'b0, 4'h0);        // R4 limit below 2
    run_cmd(16'd100, 6, 1'b1, 1'b0, 4'h0);      // R6 data out
    run_cmd(16'd100, 5, 1'b0, 1'b0, 4'h0);      // R12 odd length
    run_cmd(16'd100, 0, 1'b0, 1'b0, 4'h0);      // R9 no data
    run_cmd(16'd100, 20, 1'b0, 1'b1, 4'h5);     // R8 error

    // R10 after completion
    host_wr = 1'b1; host_wdata = 16'h1234; @(negedge clk); host_wr = 1'b0;
    check("R10 done write ignored", got_q.size(), 0);
    host_rd = 1'b1; #1;
    check("R10 done read returns 0", {16'd0, host_rdata}, 32'h0);
    @(negedge clk); host_rd = 1'b0;
    check("R10 done status kept", {24'd0, status}, 32'h41);
    finish_run();
  end
endmodule